// File: doc/BRIEF.md
# UART Register Front End with Oversampling Baud Generator

This block sits between a 32-bit word-addressed register bus and the serial transmit and receive machinery of a simple UART. It keeps the line configuration (data width, stop bits, parity, loopback, break, enables), the receive and transmit FIFO thresholds, the divider word for the baud generator and an interrupt mask. Every field is presented on dedicated output pins so the shifters and FIFOs can consume it directly.

A programmable divider turns the system clock into a one-cycle oversampling strobe, one per 2*(word+1) clocks. This matches a software recipe that halves clk/(16*baud) and subtracts one when that quotient is even. Writes to the data port become one-cycle push strobes towards the transmit path. Reads of the data port return the received byte with its error flags and emit a one-cycle pop strobe. Three status inputs from the FIFOs are combined with the mask into a single registered interrupt line.

Bus addresses are word indices: byte offset divided by four. The map is control at word 0 (byte 0x0), divider word at word 1 (byte 0x4), FIFO thresholds at word 2 (byte 0x8), interrupt at word 4 (byte 0x10) and the data port at word 5 (byte 0x14).

Top module: `uart_regfront`

## Requirements
- R1: After reset every stored register reads 0, and every configuration output, strobe, oversampling tick and the interrupt line are low.
- R2: The control word drives its outputs from these bit positions: receive timeout 4:0, stop-bit code 11:8 (code 7 means one stop bit), symbol-width code 13:12 (code 3 means 8 data bits), break 14, receive parity even 16, receive parity enable 17, transmit parity even 18, transmit parity enable 19, loopback 20, receive enable 21, transmit enable 22, baud generator enable 23. All of these read back as written.
- R3: Control bits 5, 15 and 31:24 always read 0, and writes to them have no effect.
- R4: Writing 1 to control bit 6 (receive FIFO reset) or bit 7 (transmit FIFO reset) raises the matching reset output for exactly one cycle after the write. Those bits always read back 0.
- R5: While control bit 23 is 1, the tick output is a one-cycle pulse every 2*(word+1) clocks, where word is the divider word. The first pulse comes 2*(word+1) clocks after the enabling write. The divider word is BAUD_W bits wide (16 by default), and its upper bits read 0.
- R6: While control bit 23 is 0, no tick is produced and the divider restarts from zero.
- R7: In the FIFO threshold register, bits 11:8 give the receive threshold and bits 15:12 give the transmit threshold. All other bits read 0.
- R8: Reading the interrupt register returns live status in bits 15:0 (bit 5 transmit empty, bit 7 receive overrun, bit 11 receive not empty, others 0) and the writable mask in bits 31:16. Writes to bits 15:0 are ignored.
- R9: The interrupt output, one clock after its inputs, is the OR over all bits of status AND mask. Writing 0 to the interrupt register masks every source.
- R10: A write to the data port produces a one-cycle transmit push on the next cycle, with the transmit byte equal to write data bits 7:0.
- R11: A read of the data port returns the received byte in bits 7:0, frame error in bit 8, parity error in bit 9 and break in bit 10, with 0 above. It also produces a one-cycle receive pop on the next cycle.
- R12: Read data appears in the cycle after the read strobe and holds until the next read. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| rx_timeout | output | 5 | Receive timeout setting |
| stop_code | output | 4 | Stop-bit code |
| sym_code | output | 2 | Symbol width code |
| tx_break | output | 1 | Force break on the line |
| rx_par_even | output | 1 | Receive parity even |
| rx_par_en | output | 1 | Receive parity enable |
| tx_par_even | output | 1 | Transmit parity even |
| tx_par_en | output | 1 | Transmit parity enable |
| loopback | output | 1 | Internal loopback |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| rx_thresh | output | 4 | Receive FIFO threshold |
| tx_thresh | output | 4 | Transmit FIFO threshold |
| os_tick | output | 1 | Oversampling strobe |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_word | input | 11 | Received byte with error flags |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_overrun | input | 1 | Receive overrun seen |
| rx_not_empty | input | 1 | Receive FIFO holds data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus master never raises read and write in the same cycle. They also assume the bus inputs hold known values from time zero, so that one-cycle-back references to a write or read strobe are meaningful right after reset. The bench drives every bus and status input only on falling edges, and it starts them at 0 before reset is released. Each bus access is a single-cycle strobe followed by an idle cycle. Divider words are changed only while the generator is disabled, so the tick spacing the checks expect is never disturbed by a mid-count update.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

   localparam int unsigned REG_W = 32;

   // word indices on the register bus
   localparam int unsigned IDX_CTL  = 0;
   localparam int unsigned IDX_BAUD = 1;
   localparam int unsigned IDX_FCFG = 2;
   localparam int unsigned IDX_IRQ  = 4;
   localparam int unsigned IDX_DATA = 5;

   // control word bit positions
   localparam int unsigned CB_RXTO_LO = 0;
   localparam int unsigned CB_RXRST   = 6;
   localparam int unsigned CB_TXRST   = 7;
   localparam int unsigned CB_STOP_LO = 8;
   localparam int unsigned CB_SYM_LO  = 12;
   localparam int unsigned CB_BRK     = 14;
   localparam int unsigned CB_RSVD    = 15;
   localparam int unsigned CB_RXPEVEN = 16;
   localparam int unsigned CB_RXPEN   = 17;
   localparam int unsigned CB_TXPEVEN = 18;
   localparam int unsigned CB_TXPEN   = 19;
   localparam int unsigned CB_LOOP    = 20;
   localparam int unsigned CB_RXEN    = 21;
   localparam int unsigned CB_TXEN    = 22;
   localparam int unsigned CB_BRGEN   = 23;

   // threshold register fields
   localparam int unsigned FB_RX_LO = 8;
   localparam int unsigned FB_TX_LO = 12;
   localparam int unsigned THR_W    = 4;

   // interrupt register
   localparam int unsigned IS_TXEMPTY = 5;
   localparam int unsigned IS_RXOVER  = 7;
   localparam int unsigned IS_RXNE    = 11;
   localparam int unsigned IRQ_SRC_W  = 16;
   localparam int unsigned IRQ_MSK_LO = 16;

   typedef struct packed {
      logic [4:0] rx_timeout;
      logic [3:0] stop_code;
      logic [1:0] sym_code;
      logic       tx_break;
      logic       rx_par_even;
      logic       rx_par_en;
      logic       tx_par_even;
      logic       tx_par_en;
      logic       loopback;
      logic       rx_en;
      logic       tx_en;
      logic       brg_en;
   } ctl_t;

   function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
      ctl_t c;
      c.rx_timeout  = w[CB_RXTO_LO +: 5];
      c.stop_code   = w[CB_STOP_LO +: 4];
      c.sym_code    = w[CB_SYM_LO +: 2];
      c.tx_break    = w[CB_BRK];
      c.rx_par_even = w[CB_RXPEVEN];
      c.rx_par_en   = w[CB_RXPEN];
      c.tx_par_even = w[CB_TXPEVEN];
      c.tx_par_en   = w[CB_TXPEN];
      c.loopback    = w[CB_LOOP];
      c.rx_en       = w[CB_RXEN];
      c.tx_en       = w[CB_TXEN];
      c.brg_en      = w[CB_BRGEN];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
      logic [REG_W-1:0] w;
      w = '0;
      w[CB_RXTO_LO +: 5] = c.rx_timeout;
      w[CB_STOP_LO +: 4] = c.stop_code;
      w[CB_SYM_LO +: 2]  = c.sym_code;
      w[CB_BRK]          = c.tx_break;
      w[CB_RXPEVEN]      = c.rx_par_even;
      w[CB_RXPEN]        = c.rx_par_en;
      w[CB_TXPEVEN]      = c.tx_par_even;
      w[CB_TXPEN]        = c.tx_par_en;
      w[CB_LOOP]         = c.loopback;
      w[CB_RXEN]         = c.rx_en;
      w[CB_TXEN]         = c.tx_en;
      w[CB_BRGEN]        = c.brg_en;
      return w;
   endfunction

endpackage

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
   import uart_rf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BAUD_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RXFLAG_W  = 3,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [REG_W-1:0]              bus_wdata,
   output logic [REG_W-1:0]              bus_rdata,
   output ctl_t                          ctl,
   output logic [BAUD_W-1:0]             baud_word,
   output logic [THR_W-1:0]              rx_thresh,
   output logic [THR_W-1:0]              tx_thresh,
   output logic [IRQ_SRC_W-1:0]          irq_mask,
   input  logic [IRQ_SRC_W-1:0]          irq_status,
   output logic                          rx_fifo_rst,
   output logic                          tx_fifo_rst,
   output logic                          tx_push,
   output logic [DATA_W-1:0]             tx_data,
   output logic                          rx_pop,
   input  logic [DATA_W+RXFLAG_W-1:0]    rx_word
);

   localparam int unsigned RXW = DATA_W + RXFLAG_W;

   logic sel_ctl, sel_baud, sel_fcfg, sel_irq, sel_data;
   logic [REG_W-1:0] rd_val;

   assign sel_ctl  = (bus_addr == ADDR_W'(IDX_CTL));
   assign sel_baud = (bus_addr == ADDR_W'(IDX_BAUD));
   assign sel_fcfg = (bus_addr == ADDR_W'(IDX_FCFG));
   assign sel_irq  = (bus_addr == ADDR_W'(IDX_IRQ));
   assign sel_data = (bus_addr == ADDR_W'(IDX_DATA));

   // stored configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         baud_word <= '0;
         rx_thresh <= '0;
         tx_thresh <= '0;
         irq_mask  <= '0;
      end else if (bus_wr) begin
         if (sel_ctl)  ctl       <= ctl_unpack(bus_wdata);
         if (sel_baud) baud_word <= bus_wdata[BAUD_W-1:0];
         if (sel_fcfg) begin
            rx_thresh <= bus_wdata[FB_RX_LO +: THR_W];
            tx_thresh <= bus_wdata[FB_TX_LO +: THR_W];
         end
         if (sel_irq)  irq_mask  <= bus_wdata[IRQ_MSK_LO +: IRQ_SRC_W];
      end
   end

   // self-clearing strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_fifo_rst <= 1'b0;
         tx_fifo_rst <= 1'b0;
         tx_push     <= 1'b0;
         tx_data     <= '0;
         rx_pop      <= 1'b0;
      end else begin
         rx_fifo_rst <= bus_wr && sel_ctl && bus_wdata[CB_RXRST];
         tx_fifo_rst <= bus_wr && sel_ctl && bus_wdata[CB_TXRST];
         tx_push     <= bus_wr && sel_data;
         rx_pop      <= bus_rd && sel_data;
         if (bus_wr && sel_data) tx_data <= bus_wdata[DATA_W-1:0];
      end
   end

   // read multiplexer
   always_comb begin
      rd_val = '0;
      unique case (1'b1)
         sel_ctl:  rd_val = ctl_pack(ctl);
         sel_baud: rd_val[BAUD_W-1:0] = baud_word;
         sel_fcfg: begin
            rd_val[FB_RX_LO +: THR_W] = rx_thresh;
            rd_val[FB_TX_LO +: THR_W] = tx_thresh;
         end
         sel_irq: begin
            rd_val[IRQ_SRC_W-1:0]             = irq_status;
            rd_val[IRQ_MSK_LO +: IRQ_SRC_W]   = irq_mask;
         end
         sel_data: rd_val[RXW-1:0] = rx_word;
         default:  rd_val = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bus_rdata <= '0;
            else if (bus_rd) bus_rdata <= rd_val;
         end

         AST_CTL_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && sel_ctl) |=> (bus_rdata[CB_RSVD] == 1'b0 && bus_rdata[REG_W-1:CB_BRGEN+1] == '0)); // R3
         AST_RST_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && sel_ctl) |=> (bus_rdata[CB_RXRST] == 1'b0 && bus_rdata[CB_TXRST] == 1'b0)); // R4
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_val : '0;
      end
   endgenerate

   AST_RXRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_rst |-> $past(bus_wr && sel_ctl && bus_wdata[CB_RXRST])); // R4
   AST_TXRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_rst |-> $past(bus_wr && sel_ctl && bus_wdata[CB_TXRST])); // R4
   AST_PUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(bus_wr && sel_data)); // R10
   AST_POP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(bus_rd && sel_data)); // R11

endmodule

// File: rtl/uart_rf_baud.sv
module uart_rf_baud #(
   parameter int unsigned BAUD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BAUD_W-1:0] word,
   output logic              tick
);

   logic [BAUD_W-1:0] cnt;
   logic              phase;
   logic              wrap;

   // half-period reached; >= keeps a lowered word from stalling the count
   assign wrap = en && (cnt >= word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
         tick  <= 1'b0;
      end else if (!en) begin
         cnt   <= '0;
         phase <= 1'b0;
         tick  <= 1'b0;
      end else begin
         cnt   <= wrap ? '0 : cnt + 1'b1;
         if (wrap) phase <= ~phase;
         tick  <= wrap && phase;
      end
   end

   AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tick); // R6
   AST_TICK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R5

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
   parameter int unsigned SRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] status,
   input  logic [SRC_W-1:0] mask,
   output logic             irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status & mask);
   end

   AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> !irq); // R9
   AST_IRQ_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |=> !irq); // R9

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_rf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BAUD_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RXFLAG_W  = 3,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   output logic [4:0]                 rx_timeout,
   output logic [3:0]                 stop_code,
   output logic [1:0]                 sym_code,
   output logic                       tx_break,
   output logic                       rx_par_even,
   output logic                       rx_par_en,
   output logic                       tx_par_even,
   output logic                       tx_par_en,
   output logic                       loopback,
   output logic                       rx_en,
   output logic                       tx_en,
   output logic                       rx_fifo_rst,
   output logic                       tx_fifo_rst,
   output logic [3:0]                 rx_thresh,
   output logic [3:0]                 tx_thresh,
   output logic                       os_tick,
   output logic                       tx_push,
   output logic [DATA_W-1:0]          tx_data,
   output logic                       rx_pop,
   input  logic [DATA_W+RXFLAG_W-1:0] rx_word,
   input  logic                       tx_empty,
   input  logic                       rx_overrun,
   input  logic                       rx_not_empty,
   output logic                       irq
);

   generate
      if (ADDR_W < 3 || ADDR_W > 30)
         $error("uart_regfront: ADDR_W must cover word index 5");
      if (BAUD_W < 1 || BAUD_W > REG_W)
         $error("uart_regfront: BAUD_W out of range");
      if (DATA_W < 5 || DATA_W + RXFLAG_W > REG_W)
         $error("uart_regfront: data and flag widths do not fit a word");
   endgenerate

   ctl_t                  ctl;
   logic [BAUD_W-1:0]     baud_word;
   logic [IRQ_SRC_W-1:0]  irq_mask;
   logic [IRQ_SRC_W-1:0]  irq_status;

   always_comb begin
      irq_status             = '0;
      irq_status[IS_TXEMPTY] = tx_empty;
      irq_status[IS_RXOVER]  = rx_overrun;
      irq_status[IS_RXNE]    = rx_not_empty;
   end

   uart_rf_regs #(
      .ADDR_W   (ADDR_W),
      .BAUD_W   (BAUD_W),
      .DATA_W   (DATA_W),
      .RXFLAG_W (RXFLAG_W),
      .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ctl        (ctl),
      .baud_word  (baud_word),
      .rx_thresh  (rx_thresh),
      .tx_thresh  (tx_thresh),
      .irq_mask   (irq_mask),
      .irq_status (irq_status),
      .rx_fifo_rst(rx_fifo_rst),
      .tx_fifo_rst(tx_fifo_rst),
      .tx_push    (tx_push),
      .tx_data    (tx_data),
      .rx_pop     (rx_pop),
      .rx_word    (rx_word)
   );

   uart_rf_baud #(
      .BAUD_W(BAUD_W)
   ) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ctl.brg_en),
      .word (baud_word),
      .tick (os_tick)
   );

   uart_rf_irq #(
      .SRC_W(IRQ_SRC_W)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .status(irq_status),
      .mask  (irq_mask),
      .irq   (irq)
   );

   assign rx_timeout  = ctl.rx_timeout;
   assign stop_code   = ctl.stop_code;
   assign sym_code    = ctl.sym_code;
   assign tx_break    = ctl.tx_break;
   assign rx_par_even = ctl.rx_par_even;
   assign rx_par_en   = ctl.rx_par_en;
   assign tx_par_even = ctl.tx_par_even;
   assign tx_par_en   = ctl.tx_par_en;
   assign loopback    = ctl.loopback;
   assign rx_en       = ctl.rx_en;
   assign tx_en       = ctl.tx_en;

   AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)); // R12

endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  rx_timeout;
   logic [3:0]  stop_code;
   logic [1:0]  sym_code;
   logic        tx_break, rx_par_even, rx_par_en, tx_par_even, tx_par_en;
   logic        loopback, rx_en, tx_en, rx_fifo_rst, tx_fifo_rst;
   logic [3:0]  rx_thresh, tx_thresh;
   logic        os_tick, tx_push, rx_pop, irq;
   logic [7:0]  tx_data;
   logic [10:0] rx_word = '0;
   logic        tx_empty = 1'b0;
   logic        rx_overrun = 1'b0;
   logic        rx_not_empty = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [31:0] val;
      string       req;
   } exp_t;

   exp_t rd_q[$];
   exp_t tx_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_regfront u_uart_regfront (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_timeout(rx_timeout),
      .stop_code(stop_code), .sym_code(sym_code), .tx_break(tx_break),
      .rx_par_even(rx_par_even), .rx_par_en(rx_par_en), .tx_par_even(tx_par_even),
      .tx_par_en(tx_par_en), .loopback(loopback), .rx_en(rx_en), .tx_en(tx_en),
      .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst), .rx_thresh(rx_thresh),
      .tx_thresh(tx_thresh), .os_tick(os_tick), .tx_push(tx_push), .tx_data(tx_data),
      .rx_pop(rx_pop), .rx_word(rx_word), .tx_empty(tx_empty), .rx_overrun(rx_overrun),
      .rx_not_empty(rx_not_empty), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      check(act === exp, req, act, exp);
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      exp_t e;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a == 3'd5) begin
         e.val = {24'h0, d[7:0]}; e.req = "R10";
         tx_q.push_back(e);
      end
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, input logic [31:0] exp, input string req);
      exp_t e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      e.val = exp; e.req = req;
      rd_q.push_back(e);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // read monitor: compare data one cycle after each read strobe
   initial begin
      forever begin
         logic was_rd;
         exp_t e;
         @(posedge clk);
         was_rd = bus_rd;
         @(negedge clk);
         if (was_rd) begin
            if (rd_q.size() == 0) check(1'b0, "R12", bus_rdata, 32'h0);
            else begin
               e = rd_q.pop_front();
               chk_eq(e.req, bus_rdata, e.val);
            end
         end
      end
   end

   // transmit monitor
   initial begin
      forever begin
         exp_t e;
         @(negedge clk);
         if (tx_push) begin
            if (tx_q.size() == 0) check(1'b0, "R10", {24'h0, tx_data}, 32'h0);
            else begin
               e = tx_q.pop_front();
               chk_eq(e.req, {24'h0, tx_data}, e.val);
            end
         end
      end
   end

   task automatic measure_tick(input int expect_k, input string req);
      int k;
      k = 0;
      for (int i = 1; i <= 4 * expect_k + 8; i++) begin
         @(posedge clk); @(negedge clk);
         if (os_tick) begin k = i; break; end
      end
      chk_eq(req, k, expect_k);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk_eq("R1", {irq, os_tick, rx_fifo_rst, tx_fifo_rst, tx_push, rx_pop}, 32'h0);
      chk_eq("R1", {stop_code, sym_code, rx_timeout, rx_en, tx_en}, 32'h0);
      rst_n = 1'b1;
      bus_read(3'd0, 32'h0, "R1");
      bus_read(3'd1, 32'h0, "R1");
      bus_read(3'd2, 32'h0, "R1");
      bus_read(3'd4, 32'h0, "R1");

      // R2: typical line setup
      bus_write(3'd0, 32'h00E5_3705);
      chk_eq("R2", {27'h0, rx_timeout}, 32'h5);
      chk_eq("R2", {28'h0, stop_code}, 32'h7);
      chk_eq("R2", {30'h0, sym_code}, 32'h3);
      chk_eq("R2", {24'h0, rx_par_even, rx_par_en, tx_par_even, tx_par_en, loopback, rx_en, tx_en, tx_break},
             {24'h0, 8'b1010_0110});
      bus_read(3'd0, 32'h00E5_3705, "R2");

      // R3 and R4: all ones
      bus_write(3'd0, 32'hFFFF_FFFF);
      chk_eq("R4", {30'h0, rx_fifo_rst, tx_fifo_rst}, 32'h3);
      chk_eq("R2", {30'h0, loopback, tx_break}, 32'h3);
      @(negedge clk);
      chk_eq("R4", {30'h0, rx_fifo_rst, tx_fifo_rst}, 32'h0);
      bus_read(3'd0, 32'h00FF_7F1F, "R3");
      bus_write(3'd0, 32'h0000_0040);
      chk_eq("R4", {30'h0, rx_fifo_rst, tx_fifo_rst}, 32'h2);
      bus_read(3'd0, 32'h0, "R4");
      bus_write(3'd0, 32'h0000_0080);
      chk_eq("R4", {30'h0, rx_fifo_rst, tx_fifo_rst}, 32'h1);

      // R7: thresholds
      bus_write(3'd2, 32'hFFFF_FFFF);
      bus_read(3'd2, 32'h0000_FF00, "R7");
      bus_write(3'd2, 32'h0000_3A00);
      chk_eq("R7", {24'h0, tx_thresh, rx_thresh}, 32'h3A);

      // R5 and R6: baud generator
      bus_write(3'd1, 32'hFFFF_FFFF);
      bus_read(3'd1, 32'h0000_FFFF, "R5");
      bus_write(3'd1, 32'd3);
      bus_write(3'd0, 32'h0080_0000);
      measure_tick(8, "R5");
      @(negedge clk);
      chk_eq("R5", {31'h0, os_tick}, 32'h0);
      measure_tick(7, "R5");
      bus_write(3'd0, 32'h0);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (os_tick) seen++;
      end
      chk_eq("R6", seen, 0);
      bus_write(3'd1, 32'd0);
      bus_write(3'd0, 32'h0080_0000);
      measure_tick(2, "R5");
      measure_tick(2, "R5");
      bus_write(3'd0, 32'h0);
      bus_write(3'd1, 32'd9);
      bus_write(3'd0, 32'h0080_0000);
      measure_tick(20, "R6");
      bus_write(3'd0, 32'h0);

      // R8 and R9: interrupts
      @(negedge clk);
      tx_empty = 1'b1;
      bus_write(3'd4, 32'hFFFF_FFFF);
      @(negedge clk);
      chk_eq("R9", {31'h0, irq}, 32'h1);
      bus_read(3'd4, 32'hFFFF_0020, "R8");
      @(negedge clk);
      rx_not_empty = 1'b1; rx_overrun = 1'b1;
      bus_read(3'd4, 32'hFFFF_08A0, "R8");
      bus_write(3'd4, 32'h0);
      @(negedge clk);
      chk_eq("R9", {31'h0, irq}, 32'h0);
      rx_overrun = 1'b0;
      bus_write(3'd4, 32'h0080_0000);
      @(negedge clk);
      chk_eq("R9", {31'h0, irq}, 32'h0);
      rx_overrun = 1'b1;
      @(negedge clk);
      chk_eq("R9", {31'h0, irq}, 32'h1);
      tx_empty = 1'b0; rx_overrun = 1'b0; rx_not_empty = 1'b0;

      // R10: data port writes
      bus_write(3'd5, 32'h1234_56A5);
      chk_eq("R10", {31'h0, tx_push}, 32'h1);
      @(negedge clk);
      chk_eq("R10", {31'h0, tx_push}, 32'h0);
      bus_write(3'd5, 32'h0000_003C);

      // R11: data port read
      @(negedge clk);
      rx_word = 11'h5C3;
      bus_read(3'd5, 32'h0000_05C3, "R11");
      chk_eq("R11", {31'h0, rx_pop}, 32'h1);
      @(negedge clk);
      chk_eq("R11", {31'h0, rx_pop}, 32'h0);

      // R12: unmapped addresses and hold
      bus_read(3'd3, 32'h0, "R12");
      bus_read(3'd7, 32'h0, "R12");
      rx_word = 11'h0FF;
      bus_read(3'd5, 32'h0000_00FF, "R12");
      repeat (3) @(negedge clk);
      chk_eq("R12", bus_rdata, 32'h0000_00FF);

      repeat (2) @(negedge clk);
      chk_eq("R12", rd_q.size(), 0);
      chk_eq("R10", tx_q.size(), 0);
      finish_run();
   end

endmodule